// File: doc/BRIEF.md
# Configurable 32-Source Interrupt Controller

The block gathers 32 interrupt request lines and presents them to a processor through a small word-addressed register port. Each source has its own settings for enable, class (normal or critical), detection style (edge or level) and active sense (high/rising or low/falling). Conditioned requests are latched into a pending status word. The enabled pending bits are then reduced into two registered request outputs, one per class.

Software reads the pending, enable, class, sense and detection words. It clears pending bits by writing ones. A level-sensed bit cannot be cleared while its line is still active. Several controllers can be cascaded by feeding one controller's request output into another controller's input line.

Top module: `intr_hub`

## Requirements
- R1: Input `irq_i[n]` is source n, and source n occupies bit 31-n of every register word, so source 0 is the most significant bit.
- R2: Word offsets are: pending status 0x0, enable 0x2, critical class 0x3, sense 0x4, detection 0x5, masked status 0x6. Every other offset reads zero and ignores writes. Writes to offset 0x6 change no register.
- R3: After reset, enable, class, sense and detection read zero, and both outputs are low. With these defaults, a source whose line is low becomes pending.
- R4: Detection bit 1 selects edge and 0 selects level. Sense bit 1 selects rising edge or high level, and 0 selects falling edge or low level.
- R5: An edge source's line passes a two-flop synchronizer. Its pending bit reads set after the third rising clock edge following the qualifying transition. The bit stays set after the line returns, until software clears it.
- R6: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. Writing 0xFFFFFFFF clears every bit whose level line is inactive.
- R7: A level source's pending bit stays set through a clear while its line is active, whether or not the source is enabled.
- R8: Masked status reads as pending AND enable, and reads zero when no enabled bit is pending.
- R9: The critical output is the OR of enabled pending bits with the class bit set. The normal output is the same OR over bits with the class bit clear. Each output is registered, so it follows masked status one clock later, and a level input reaches the output at the fourth rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Request lines, bit n is source n |
| addr_i | input | 4 | Register word offset |
| wr_en_i | input | 1 | Write strobe, applied at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_norm_o | output | 1 | Normal-class request |
| irq_crit_o | output | 1 | Critical-class request |

## Verification
A line change is captured by the synchronizer at the first and second rising edges. The pending bit is set at the third edge, and the outputs change at the fourth. Register writes take effect at the edge that samples them, and reads are combinational. The bench drives stimulus at falling edges and counts falling edges before sampling. For the pipeline it checks status at two edges (still clear), at three edges (set), and checks the output at four. Clear-versus-active races are checked right after the clearing edge.

// File: rtl/intr_hub_pkg.sv
package intr_hub_pkg;
  localparam int unsigned NSRC   = 32;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_EN    = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_CRIT  = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_POL   = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_TRIG  = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 4'h6;
endpackage

// File: rtl/intr_hub_cond.sv
module intr_hub_cond #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic pol_i,
  output logic act_o,
  output logic edge_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // idle-high reset matches the active-low default sense
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign act_o = pol_i ? sync_q[MSB] : ~sync_q[MSB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= act_o;
  end

  assign edge_o = act_o & ~prev_q;
endmodule

// File: rtl/intr_hub_regs.sv
module intr_hub_regs
  import intr_hub_pkg::*;
#(
  parameter int unsigned N  = NSRC,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [N-1:0]  wdata_i,
  input  logic [N-1:0]  stat_i,
  output logic [N-1:0]  en_o,
  output logic [N-1:0]  crit_o,
  output logic [N-1:0]  pol_o,
  output logic [N-1:0]  trig_o,
  output logic [N-1:0]  clr_o,
  output logic [N-1:0]  rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      crit_o <= '0;
      pol_o  <= '0;
      trig_o <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFS_EN:   en_o   <= wdata_i;
        OFS_CRIT: crit_o <= wdata_i;
        OFS_POL:  pol_o  <= wdata_i;
        OFS_TRIG: trig_o <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign clr_o = (wr_en_i && addr_i == OFS_STAT) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      OFS_STAT:  rdata_o = stat_i;
      OFS_EN:    rdata_o = en_o;
      OFS_CRIT:  rdata_o = crit_o;
      OFS_POL:   rdata_o = pol_o;
      OFS_TRIG:  rdata_o = trig_o;
      OFS_MSTAT: rdata_o = stat_i & en_o;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/intr_hub_out.sv
module intr_hub_out #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] crit_i,
  output logic         norm_o,
  output logic         crit_o
);
  logic [N-1:0] masked;
  assign masked = stat_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      norm_o <= 1'b0;
      crit_o <= 1'b0;
    end else begin
      norm_o <= |(masked & ~crit_i);
      crit_o <= |(masked & crit_i);
    end
  end
endmodule

// File: rtl/intr_hub.sv
module intr_hub
  import intr_hub_pkg::*;
#(
  parameter int unsigned N  = NSRC,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic [N-1:0]  wdata_i,
  output logic [N-1:0]  rdata_o,
  output logic          irq_norm_o,
  output logic          irq_crit_o
);
  logic [N-1:0] en_q, crit_q, pol_q, trig_q, clr_w;
  logic [N-1:0] act_w, edge_w, set_w, stat_q;

  // source n lives at bit N-1-n
  for (genvar n = 0; n < N; n++) begin : g_src
    localparam int unsigned B = N - 1 - n;
    intr_hub_cond #(.SYNC_STAGES(2)) u_cond (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (irq_i[n]),
      .pol_i  (pol_q[B]),
      .act_o  (act_w[B]),
      .edge_o (edge_w[B])
    );
  end

  assign set_w = (trig_q & edge_w) | (~trig_q & act_w);

  // set dominates clear: an active level re-latches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_w) | set_w;
  end

  intr_hub_regs #(.N(N), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .stat_i  (stat_q),
    .en_o    (en_q),
    .crit_o  (crit_q),
    .pol_o   (pol_q),
    .trig_o  (trig_q),
    .clr_o   (clr_w),
    .rdata_o (rdata_o)
  );

  intr_hub_out #(.N(N)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (stat_q),
    .en_i   (en_q),
    .crit_i (crit_q),
    .norm_o (irq_norm_o),
    .crit_o (irq_crit_o)
  );
endmodule

// File: rtl/intr_hub_chk.sv
module intr_hub_chk #(
  parameter int unsigned N  = 32,
  parameter int unsigned AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          wr_en_i,
  input logic [N-1:0]  wdata_i,
  input logic [N-1:0]  rdata_o,
  input logic          irq_norm_o,
  input logic          irq_crit_o,
  input logic [N-1:0]  stat_q,
  input logic [N-1:0]  en_q,
  input logic [N-1:0]  crit_q,
  input logic [N-1:0]  pol_q,
  input logic [N-1:0]  trig_q,
  input logic [N-1:0]  act_w
);
  logic [N-1:0] clr_seen;
  assign clr_seen = (wr_en_i && addr_i == 4'h0) ? wdata_i : '0;

  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(stat_q & trig_q & ~clr_seen) & ~stat_q) == '0));  // R5

  AST_LVL_RELATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(act_w & ~trig_q) & ~stat_q) == '0));  // R7

  AST_OUT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_q) == '0) |-> (!irq_norm_o && !irq_crit_o));  // R9

  AST_MSTAT_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 4'h6) |=>
      ($stable(en_q) && $stable(crit_q) && $stable(pol_q) && $stable(trig_q)));  // R2

  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 4'h1 || addr_i > 4'h6) |-> (rdata_o == '0));  // R2

  AST_MSTAT_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 4'h6) |-> (rdata_o == (stat_q & en_q)));  // R8
endmodule

bind intr_hub intr_hub_chk #(.N(N), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_en_i    (wr_en_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_norm_o (irq_norm_o),
  .irq_crit_o (irq_crit_o),
  .stat_q     (stat_q),
  .en_q       (en_q),
  .crit_q     (crit_q),
  .pol_q      (pol_q),
  .trig_q     (trig_q),
  .act_w      (act_w)
);

// File: tb/intr_hub_bench.sv
module intr_hub_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_i = '1;
  logic [3:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_norm_o, irq_crit_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  intr_hub u_intr_hub (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .irq_norm_o (irq_norm_o),
    .irq_crit_o (irq_crit_o)
  );

  function automatic logic [31:0] sb(int n);
    return 32'h1 << (31 - n);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    foreach (v[i]) ;
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], v); chk($sformatf("R3 reset read offset %0d", a), v, '0);
    end
    chk("R3 reset outputs", {30'd0, irq_norm_o, irq_crit_o}, '0);
  endtask

  task automatic t_timing();
    logic [31:0] v;
    wr(4'h2, sb(4));
    irq_i[4] = 1'b0;
    tick(2); rd(4'h0, v); chk("R5 status not before third edge", v, '0);
    tick(1); rd(4'h0, v); chk("R1 R3 low level pends at bit 27", v, sb(4));
    chk("R9 output not before fourth edge", {31'd0, irq_norm_o}, '0);
    tick(1); chk("R9 normal output at fourth edge", {31'd0, irq_norm_o}, 32'd1);
    chk("R9 critical output idle", {31'd0, irq_crit_o}, '0);
    rd(4'h6, v); chk("R8 masked status", v, sb(4));
  endtask

  task automatic t_level_sticky();
    logic [31:0] v;
    wr(4'h0, sb(4)); rd(4'h0, v); chk("R7 clear while active enabled", v, sb(4));
    wr(4'h2, '0);
    wr(4'h0, sb(4)); rd(4'h0, v); chk("R7 clear while active disabled", v, sb(4));
    rd(4'h6, v); chk("R8 masked zero when disabled", v, '0);
    tick(1); chk("R9 output drops after disable", {31'd0, irq_norm_o}, '0);
    irq_i[4] = 1'b1; tick(3);
    rd(4'h0, v); chk("R7 level bit held until cleared", v, sb(4));
    wr(4'h0, sb(4)); rd(4'h0, v); chk("R6 clear after release", v, '0);
  endtask

  task automatic t_edge_rise();
    logic [31:0] v;
    wr(4'h5, sb(0)); wr(4'h4, sb(0)); tick(2);
    wr(4'h0, sb(0)); rd(4'h0, v); chk("R6 clear config artefact", v, '0);
    irq_i[0] = 1'b0; tick(4);
    rd(4'h0, v); chk("R4 falling ignored in rising mode", v, '0);
    irq_i[0] = 1'b1;
    tick(2); rd(4'h0, v); chk("R5 edge not before third edge", v, '0);
    tick(1); rd(4'h0, v); chk("R5 rising edge latched", v, sb(0));
    irq_i[0] = 1'b0; tick(4);
    rd(4'h0, v); chk("R5 edge bit held after line drop", v, sb(0));
    wr(4'h0, '0); rd(4'h0, v); chk("R6 writing zero keeps bit", v, sb(0));
    wr(4'h0, sb(0)); rd(4'h0, v); chk("R6 writing one clears bit", v, '0);
  endtask

  task automatic t_edge_fall();
    logic [31:0] v;
    wr(4'h5, sb(0) | sb(1));
    @(negedge clk_i); irq_i[1] = 1'b0;
    @(negedge clk_i); irq_i[1] = 1'b1;
    tick(3); rd(4'h0, v); chk("R4 R5 falling pulse latched", v, sb(1));
    wr(4'h0, '1); rd(4'h0, v); chk("R6 all ones clears", v, '0);
  endtask

  task automatic t_classes();
    logic [31:0] v;
    wr(4'h3, sb(2)); wr(4'h2, sb(2) | sb(6));
    irq_i[2] = 1'b0; tick(4);
    chk("R9 critical source drives critical", {30'd0, irq_crit_o, irq_norm_o}, 32'd2);
    irq_i[6] = 1'b0; tick(4);
    chk("R9 both classes pending", {30'd0, irq_crit_o, irq_norm_o}, 32'd3);
    wr(4'h2, '0); tick(1);
    chk("R9 disable quiets outputs", {30'd0, irq_crit_o, irq_norm_o}, '0);
    irq_i[2] = 1'b1; irq_i[6] = 1'b1; tick(3);
    wr(4'h0, '1); rd(4'h0, v); chk("R6 clear class sources", v, '0);
    wr(4'h4, sb(0) | sb(7)); tick(3);
    rd(4'h0, v); chk("R4 high level active", v, sb(7));
    irq_i[7] = 1'b0; tick(3);
    wr(4'h0, sb(7)); rd(4'h0, v); chk("R4 high level released clears", v, '0);
  endtask

  task automatic t_bus();
    logic [31:0] v;
    wr(4'h6, '1); rd(4'h2, v); chk("R2 masked write leaves enable", v, '0);
    rd(4'h3, v); chk("R2 masked write leaves class", v, sb(2));
    wr(4'h1, '1); wr(4'h7, '1); wr(4'h8, '1);
    rd(4'h1, v); chk("R2 offset 1 reads zero", v, '0);
    rd(4'h7, v); chk("R2 offset 7 reads zero", v, '0);
    rd(4'h8, v); chk("R2 offset 8 reads zero", v, '0);
    rd(4'h5, v); chk("R2 detection unchanged", v, sb(0) | sb(1));
    rd(4'h4, v); chk("R2 sense unchanged", v, sb(0) | sb(7));
    wr(4'h2, '1); rd(4'h6, v); chk("R8 nothing pending reads zero", v, '0);
    tick(1); chk("R9 no output when nothing pending", {30'd0, irq_crit_o, irq_norm_o}, '0);
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    t_reset();
    t_timing();
    t_level_sticky();
    t_edge_rise();
    t_edge_fall();
    t_classes();
    t_bus();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule